// File: doc/BRIEF.md
# Serial Peripheral Slave with Sticky Status Flags

This block sits on a host processor's register bus and serves as a slave on an SPI bus. While the master holds slave select low, the block takes one character in on MOSI and at the same time sends a preloaded character out on MISO. Both directions move the most significant bit first. Two control bits set the clock behaviour. The polarity bit chooses which serial clock edge samples data. The phase bit chooses whether the first outgoing bit is driven as soon as slave select asserts or only after the first clock edge.

The serial clock, MOSI and slave select cross into the system clock domain through two-flop synchronizers, and their edges are detected there. The system clock must run at least four times faster than the serial clock. A busy flag shows that a character is in progress. A sticky completion flag shows that a full character has been received. The same buffer register holds both the received character and the next character to send. The host reads the received character from it and writes the next reply into it. An interrupt output follows the completion flag when the interrupt is enabled.

Top module: `spi_slave_flags`

## Requirements
- R1: After reset, every register reads 0 (control, status and data), MISO is 0 and the interrupt is low.
- R2: Register map, selected by a 2-bit address. Address 0 is control: bit 0 is polarity, bit 1 is phase, bit 2 is interrupt enable. Address 1 is status: bit 0 is busy, bit 1 is done. Address 2 is the shared data buffer. Address 3 reads 0.
- R3: The transfer is full duplex and MSB first. After 8 sample edges, the data buffer holds the 8 MOSI bits, and MISO has carried the character that was in the buffer when slave select asserted.
- R4: With polarity 0, data is sampled on rising serial clock edges. With polarity 1, data is sampled on falling edges. The opposite edge shifts MISO.
- R5: With phase 0, MISO shows the MSB of the outgoing character soon after slave select asserts. With phase 1, MISO stays 0 until the first shift edge.
- R6: Busy rises when slave select asserts. Busy clears when the eighth bit is sampled, or when slave select deasserts.
- R7: Done is set when the eighth bit is sampled. At that moment the buffer takes the received character.
- R8: Once set, done stays set until the host writes 0 to status bit 1. Writing 1 to that bit leaves done unchanged.
- R9: The interrupt output is high exactly when done and interrupt enable are both 1.
- R10: If slave select deasserts before the eighth sample, the partial character is dropped. The buffer keeps its contents, done is not set, and busy clears.
- R11: Serial clock edges after the eighth sample are ignored until slave select asserts again. The buffer keeps the first character and done stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_ni | input | 1 | Slave select, active low |
| miso_o | output | 1 | Serial data to the master (0 when not selected) |
| reg_addr_i | input | 2 | Host register address |
| reg_we_i | input | 1 | Host write strobe |
| reg_wdata_i | input | DATA_W | Host write data |
| reg_rdata_o | output | DATA_W | Host read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Interrupt: done AND interrupt enable |

## Verification
The bench builds the block with DATA_W = 8 and two synchronizer stages. Each serial half-period lasts eight system clocks, so every edge passes the synchronizer and edge detector well before the next one arrives. With 8-bit characters, the bench can run all four clock modes on random characters within a few hundred cycles per transfer. It also covers short transfers aborted after four bits and overlong ones of sixteen clocks, and it exercises every boundary of the bit counter.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_W     = 3;
  localparam int unsigned STAT_BUSY  = 0;
  localparam int unsigned STAT_DONE  = 1;

  typedef struct packed {
    logic irq_en;
    logic cpha;
    logic cpol;
  } ctrl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sel_start_i,
  input  logic              sel_end_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              miso_o,
  output logic              busy_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  logic              sel_q;
  logic              out_en_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-2:0] rx_sh_q;
  logic              sample_edge;
  logic              shift_edge;
  logic              do_sample;
  logic              do_shift;
  logic [DATA_W-1:0] rx_next;

  assign sample_edge = cpol_i ? sclk_fall_i : sclk_rise_i;
  assign shift_edge  = cpol_i ? sclk_rise_i : sclk_fall_i;
  assign do_sample   = sel_q && sample_edge && (cnt_q != CNT_FULL);
  // shift only between samples: leading shift edge (phase 1) and trailing one are not shifts
  assign do_shift    = sel_q && shift_edge && (cnt_q != '0) && (cnt_q != CNT_FULL);
  assign rx_next     = {rx_sh_q, mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= 1'b0;
      out_en_q <= 1'b0;
      cnt_q    <= '0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
    end else if (sel_start_i) begin
      sel_q    <= 1'b1;
      out_en_q <= ~cpha_i;
      cnt_q    <= '0;
      tx_sh_q  <= tx_data_i;
      rx_sh_q  <= '0;
    end else if (sel_end_i) begin
      sel_q    <= 1'b0;
      out_en_q <= 1'b0;
    end else if (sel_q) begin
      if (do_sample) begin
        rx_sh_q <= rx_next[DATA_W-2:0];
        cnt_q   <= cnt_q + 1'b1;
      end
      if (shift_edge) out_en_q <= 1'b1;
      if (do_shift) tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
    end
  end

  assign miso_o     = sel_q & out_en_q & tx_sh_q[DATA_W-1];
  assign busy_o     = sel_q && (cnt_q != CNT_FULL);
  assign rx_valid_o = do_sample && (cnt_q == CNT_LAST);
  assign rx_data_o  = rx_next;
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_slave_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output ctrl_t             ctrl_o,
  output logic              done_o,
  output logic [DATA_W-1:0] buf_o
);
  ctrl_t             ctrl_q;
  logic              done_q;
  logic [DATA_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (we_i) begin
        unique case (reg_sel_e'(addr_i))
          REG_CTRL: ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
          REG_STAT: if (!wdata_i[STAT_DONE]) done_q <= 1'b0;
          REG_DATA: buf_q <= wdata_i;
          default: ;
        endcase
      end
      // a completing character wins over a same-cycle host access
      if (rx_valid_i) begin
        buf_q  <= rx_data_i;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_e'(addr_i))
      REG_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      REG_STAT: begin
        rdata_o[STAT_BUSY] = busy_i;
        rdata_o[STAT_DONE] = done_q;
      end
      REG_DATA: rdata_o = buf_q;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign done_o = done_q;
  assign buf_o  = buf_q;
endmodule

// File: rtl/spi_slave_flags.sv
module spi_slave_flags
  import spi_slave_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              ss_ni,
  output logic              miso_o,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [2:0]        sync_q;
  logic              ss_n_s;
  logic              sclk_s;
  logic              mosi_s;
  logic [1:0]        rise;
  logic [1:0]        fall;
  logic              busy;
  logic              rx_valid;
  logic [DATA_W-1:0] rx_data;
  logic [DATA_W-1:0] buf_data;
  logic              done;
  ctrl_t             ctrl;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sclk_i, mosi_i}),
    .q_o   (sync_q)
  );

  assign {ss_n_s, sclk_s, mosi_s} = sync_q;

  spi_edge_det #(.WIDTH(2), .RST_VAL(2'b10)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i ({ss_n_s, sclk_s}),
    .rise_o(rise),
    .fall_o(fall)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpol_i     (ctrl.cpol),
    .cpha_i     (ctrl.cpha),
    .sclk_rise_i(rise[0]),
    .sclk_fall_i(fall[0]),
    .sel_start_i(fall[1]),
    .sel_end_i  (rise[1]),
    .mosi_i     (mosi_s),
    .tx_data_i  (buf_data),
    .miso_o     (miso_o),
    .busy_o     (busy),
    .rx_valid_o (rx_valid),
    .rx_data_o  (rx_data)
  );

  spi_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr_i),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy),
    .rx_valid_i(rx_valid),
    .rx_data_i (rx_data),
    .ctrl_o    (ctrl),
    .done_o    (done),
    .buf_o     (buf_data)
  );

  assign irq_o = done & ctrl.irq_en;
endmodule

// File: rtl/spi_slave_flags_chk.sv
module spi_slave_flags_chk
  import spi_slave_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ss_n_s,
  input logic              busy,
  input logic              done,
  input logic              irq_en,
  input logic              miso_o,
  input logic              irq_o,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [DATA_W-1:0] reg_wdata_i
);
  p_irq_needs_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (done && irq_en));

  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !(reg_we_i && reg_addr_i == REG_STAT && !reg_wdata_i[STAT_DONE])) |=> done);

  p_done_after_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done) |-> $past(busy));

  p_busy_fall_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> ($past(ss_n_s) || done));

  p_busy_on_select_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss_n_s) |=> busy);

  p_miso_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_n_s |=> !miso_o);
endmodule

bind spi_slave_flags spi_slave_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ss_n_s     (ss_n_s),
  .busy       (busy),
  .done       (done),
  .irq_en     (ctrl.irq_en),
  .miso_o     (miso_o),
  .irq_o      (irq_o),
  .reg_addr_i (reg_addr_i),
  .reg_we_i   (reg_we_i),
  .reg_wdata_i(reg_wdata_i)
);

// File: tb/sim_spi_slave_flags.sv
`timescale 1ns/1ps
module sim_spi_slave_flags;
  localparam int DW   = 8;
  localparam int HALF = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sclk_i = 1'b0;
  logic          mosi_i = 1'b0;
  logic          ss_ni = 1'b1;
  logic          miso_o;
  logic [1:0]    reg_addr_i = '0;
  logic          reg_we_i = 1'b0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic [DW-1:0] reg_rdata_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  spi_slave_flags #(.DATA_W(DW), .SYNC_STAGES(2)) u0 (
    .clk_i, .rst_ni, .sclk_i, .mosi_i, .ss_ni, .miso_o,
    .reg_addr_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [DW-1:0] ctrl_val(input bit pol, input bit pha, input bit ie);
    return {5'b0, ie, pha, pol};
  endfunction

  // master side of one selection; pre = MISO before the first edge, st = status before release
  task automatic xfer(input bit pol, input bit pha, input logic [DW-1:0] mo, input int nbits,
                      output logic [DW-1:0] mi, output logic pre, output logic [DW-1:0] st);
    mi = '0;
    @(negedge clk_i);
    sclk_i = pol ^ pha;
    gap(HALF);
    ss_ni = 1'b0;
    if (!pha) mosi_i = mo[DW-1];
    gap(HALF);
    pre = miso_o;
    for (int i = 0; i < nbits; i++) begin
      if (pha) begin
        sclk_i = ~sclk_i;
        mosi_i = mo[DW-1-(i%DW)];
        gap(HALF);
        if (i < DW) mi = {mi[DW-2:0], miso_o};
        sclk_i = ~sclk_i;
        gap(HALF);
      end else begin
        if (i < DW) mi = {mi[DW-2:0], miso_o};
        sclk_i = ~sclk_i;
        gap(HALF);
        sclk_i = ~sclk_i;
        mosi_i = mo[DW-1-((i+1)%DW)];
        gap(HALF);
      end
    end
    rd(2'd1, st);
    ss_ni = 1'b1;
    gap(2*HALF);
  endtask

  initial begin
    logic [DW-1:0] v, mi, st, tx, mo;
    logic pre;
    bit pol, pha;
    void'($urandom(32'h5a17));

    gap(3);
    rst_ni = 1'b1;
    gap(2);
    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 status", v, 0);
    rd(2'd2, v); check("R1 data", v, 0);
    check("R1 miso", miso_o, 0);
    check("R1 irq", irq_o, 0);

    // R2 register map
    wr(2'd0, 8'hff); rd(2'd0, v); check("R2 ctrl width", v, 8'h07);
    wr(2'd2, 8'hc3); rd(2'd2, v); check("R2 data", v, 8'hc3);
    rd(2'd3, v); check("R2 unused addr", v, 0);
    wr(2'd0, 8'h00);

    // R6 busy on select, cleared on deselect
    @(negedge clk_i); ss_ni = 1'b0;
    gap(6);
    rd(2'd1, v); check("R6 busy on select", v, 8'h01);
    ss_ni = 1'b1;
    gap(6);
    rd(2'd1, v); check("R6 busy clear on deselect", v, 8'h00);

    // directed phase-1 check: MISO quiet before first edge although MSB=1 (R5)
    wr(2'd0, ctrl_val(0, 1, 0));
    wr(2'd2, 8'hA5);
    xfer(0, 1, 8'h3C, 8, mi, pre, st);
    check("R5 phase1 pre-edge miso", pre, 0);
    check("R3 miso char", mi, 8'hA5);
    rd(2'd2, v); check("R3 rx char", v, 8'h3C);
    check("R6 R7 status before release", st, 8'h02);

    // R8 sticky done
    wr(2'd1, 8'h02); rd(2'd1, v); check("R8 write 1 keeps done", v, 8'h02);
    // R9 interrupt gating
    check("R9 irq off when disabled", irq_o, 0);
    wr(2'd0, ctrl_val(0, 1, 1)); gap(1);
    check("R9 irq on", irq_o, 1);
    wr(2'd1, 8'h00); rd(2'd1, v); check("R8 write 0 clears", v, 8'h00);
    check("R9 irq follows done", irq_o, 0);

    // R10 abort after four bits
    wr(2'd0, ctrl_val(1, 0, 0));
    wr(2'd2, 8'h5E);
    xfer(1, 0, 8'hF0, 4, mi, pre, st);
    rd(2'd2, v); check("R10 buffer kept", v, 8'h5E);
    rd(2'd1, v); check("R10 no done, not busy", v, 8'h00);

    // R11 extra edges ignored
    wr(2'd0, ctrl_val(1, 1, 0));
    wr(2'd2, 8'h81);
    xfer(1, 1, 8'h6D, 16, mi, pre, st);
    rd(2'd2, v); check("R11 first char kept", v, 8'h6D);
    check("R11 miso char", mi, 8'h81);
    rd(2'd1, v); check("R11 done set", v, 8'h02);
    wr(2'd1, 8'h00);

    // random transfers over all modes (R3 R4 R5 R6 R7)
    for (int k = 0; k < 24; k++) begin
      pol = $urandom_range(1);
      pha = $urandom_range(1);
      tx  = DW'($urandom);
      mo  = DW'($urandom);
      if (k < 4) begin pol = k[0]; pha = k[1]; end
      wr(2'd0, ctrl_val(pol, pha, 0));
      wr(2'd1, 8'h00);
      wr(2'd2, tx);
      xfer(pol, pha, mo, 8, mi, pre, st);
      rd(2'd2, v); check("R3 R4 rx char", v, mo);
      check("R3 R4 miso char", mi, tx);
      check("R5 first miso bit", pre, pha ? 1'b0 : tx[DW-1]);
      check("R6 R7 busy low done high at 8th bit", st, 8'h02);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule